// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Dead-Time Insertion

This block is an up-counting PWM timer that drives three half-bridge style channels. Each channel produces a main gate signal and a complementary gate signal derived from a reference waveform. The reference of a channel is high while a phase-shifted copy of the shared count is below that channel's compare value. The phase shift is programmable per channel, so the three channels can be staggered in time.

Between the two gates of a pair, a dead-time inserter holds off each rising edge until the reference has stayed on that side for the programmed dead time. Falling edges pass through without extra delay. The two gates of a channel are therefore never high together. The dead time comes from an 8-bit code with four ranges of increasing step size, so one byte covers both short and long dead times.

Period, compare, phase and dead-time settings are plain input ports. They are captured into shadow registers only at the period boundary, or continuously while the block is disabled. A typical setup uses a 168 MHz clock with a period value of 3359 (50 kHz), phase steps of 504 counts (3 µs) and dead-time code 0x94 (168 clocks, 1 µs).

Top module: `tri_pwm_dt`

## Requirements
- R1: While enabled, the count runs 0, 1, …, P and then returns to 0, where P is the captured period value. One PWM period is therefore P+1 clocks.
- R2: A channel's reference is high in a cycle exactly when ((count + phase) mod (P+1)) < compare. The phase value must not exceed P. A compare value above P gives a reference that is always high.
- R3: The main gate is high in the cycle after edge j exactly when the reference was high in each of the dt+1 reference cycles up to and including cycle j-1, where cycle 0 is the first enabled cycle. As a result, the main gate rises dt clocks after the reference does, with two edges of pipeline latency.
- R4: The complementary gate follows the same rule as R3 with the reference low. The disabled state counts as a low reference at cycle -1.
- R5: A gate falls two edges after its side of the reference goes inactive, with no dead-time delay. The main gate and the complementary gate of a channel are never high together. With dt = 0 they are exact complements.
- R6: A reference pulse of L ≤ dt cycles leaves the matching gate low for the whole pulse. A longer pulse yields L−dt high cycles.
- R7: Dead-time code c decodes as follows: c[7]=0 gives c clocks; c[7:5]=10x gives (64+c[5:0])×2 clocks; c[7:5]=110 gives (32+c[4:0])×8 clocks; c[7:5]=111 gives (32+c[4:0])×16 clocks. The maximum is 1008 clocks.
- R8: Period, compare, phase and dead-time inputs are captured on the edge where the count wraps from P, or on any edge while disabled. An input change in mid-period has no effect until the next wrap.
- R9: Reset or a low enable drives all six gates low from the next edge and holds the count at 0. After enable rises, the first enabled cycle uses count 0, and both gates of every channel wait out the dead time.
- R10: With P=3359, compare 1680, phases 0/504/1008 and code 0x94, the dead time is 168 clocks. The rising edges of channels 1 and 2 are spaced by 504 counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces gates low and count to 0 |
| period_i | input | CNT_W | Period value P (count limit) |
| cmp_i | input | NCH*CNT_W | Compare values, channel n in bits [n*CNT_W +: CNT_W] |
| phase_i | input | NCH*CNT_W | Phase offsets, same packing as cmp_i |
| dt_code_i | input | 8 | Dead-time code (R7 ranges) |
| gate_hi | output | NCH | Main gate per channel |
| gate_lo | output | NCH | Complementary gate per channel |

## Verification
A reference value formed from the count in cycle i reaches the gates after edge i+2: it is registered once into the channel state and once more into the output flops. A rising edge appears a further dt cycles later, and a setting change takes effect from the cycle after the wrap edge. The bench enables the block at a falling clock edge and samples at every following falling edge. The sample after enabled edge j is compared with a model built from R2 to R4, evaluated at reference index j-1, over a window of dt+1 indices. The reload test restricts its comparison against the old settings to samples whose reference index does not pass the wrap. Steady-state counts of high cycles are taken only over the second full period, so the start-up dead time cannot leak into them.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  // width of the dead-time counter: covers the largest decoded value (1008)
  localparam int DTC_W = 10;
  typedef logic [DTC_W-1:0] dt_cnt_t;

  // the four step-size ranges of the dead-time code
  typedef enum logic [1:0] {
    DT_FINE = 2'd0,
    DT_X2   = 2'd1,
    DT_X8   = 2'd2,
    DT_X16  = 2'd3
  } dt_range_e;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] period_o,
  output logic             load_o
);
  // shadow capture happens at the wrap edge or while idle
  assign load_o = !en || (cnt_o >= period_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_o <= '0;
    end else if (load_o) begin
      period_o <= period_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_o <= '0;
    end else if (cnt_o >= period_o) begin
      cnt_o <= '0;
    end else begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  // R1: count never exceeds the captured limit
  a_r1_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_o <= period_o);
  // R1: reaching the limit returns the count to zero
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && cnt_o == period_o) |=> cnt_o == '0);
  // R8: the captured period only moves at a wrap or while idle
  a_r8_period_hold: assert property (@(posedge clk) disable iff (rst)
    (en && cnt_o < period_o) |=> $stable(period_o));
  // R9: idle holds the count at zero
  a_r9_cnt_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt_o == '0);
endmodule

// File: rtl/pwm_dt_decode.sv
module pwm_dt_decode
  import pwm_gate_pkg::*;
(
  input  logic [7:0] code_i,
  output dt_cnt_t    dt_o
);
  dt_range_e rng;

  always_comb begin
    casez (code_i[7:5])
      3'b0??:  rng = DT_FINE;
      3'b10?:  rng = DT_X2;
      3'b110:  rng = DT_X8;
      default: rng = DT_X16;
    endcase
  end

  always_comb begin
    unique case (rng)
      DT_FINE: dt_o = dt_cnt_t'(int'(code_i));
      DT_X2:   dt_o = dt_cnt_t'((64 + int'(code_i[5:0])) * 2);
      DT_X8:   dt_o = dt_cnt_t'((32 + int'(code_i[4:0])) * 8);
      default: dt_o = dt_cnt_t'((32 + int'(code_i[4:0])) * 16);
    endcase
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_gate_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] phase_i,
  input  dt_cnt_t          dt_i,
  output logic             hi_o,
  output logic             lo_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cmp_q, ph_q;
  logic [SUM_W-1:0] sum, span, pcnt;
  logic             ref_now;
  logic             lvl;      // registered reference level
  dt_cnt_t          run;      // cycles the level has held, saturating

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      ph_q  <= '0;
    end else if (load_i) begin
      cmp_q <= cmp_i;
      ph_q  <= phase_i;
    end
  end

  // phase-shifted count folded back into one period
  always_comb begin
    sum     = {1'b0, cnt_i} + {1'b0, ph_q};
    span    = {1'b0, period_i} + SUM_W'(1);
    pcnt    = (sum >= span) ? (sum - span) : sum;
    ref_now = pcnt < {1'b0, cmp_q};
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      lvl  <= 1'b0;
      run  <= '0;
      hi_o <= 1'b0;
      lo_o <= 1'b0;
    end else begin
      hi_o <= lvl && (run >= dt_i);
      lo_o <= !lvl && (run >= dt_i);
      if (ref_now != lvl) begin
        lvl <= ref_now;
        run <= '0;
      end else if (run != '1) begin
        run <= run + 1'b1;
      end
    end
  end

  // R5: the two gates of a pair are never on together
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(hi_o && lo_o));
  // R5: a low level turns the main gate off at the next edge
  a_r5_hi_off: assert property (@(posedge clk) disable iff (rst)
    !lvl |=> !hi_o);
  // R5: a high level turns the complementary gate off at the next edge
  a_r5_lo_off: assert property (@(posedge clk) disable iff (rst)
    lvl |=> !lo_o);
  // R8: compare stays put in mid-period
  a_r8_cmp_hold: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(cmp_q));
endmodule

// File: rtl/tri_pwm_dt.sv
module tri_pwm_dt
  import pwm_gate_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [CNT_W-1:0]     period_i,
  input  logic [NCH*CNT_W-1:0] cmp_i,
  input  logic [NCH*CNT_W-1:0] phase_i,
  input  logic [7:0]           dt_code_i,
  output logic [NCH-1:0]       gate_hi,
  output logic [NCH-1:0]       gate_lo
);
  logic [CNT_W-1:0] cnt, period_q;
  logic             load;
  dt_cnt_t          dt_now, dt_q;

  pwm_timebase #(.CNT_W(CNT_W)) u_base (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .period_i (period_i),
    .cnt_o    (cnt),
    .period_o (period_q),
    .load_o   (load)
  );

  pwm_dt_decode u_dec (
    .code_i (dt_code_i),
    .dt_o   (dt_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dt_q <= '0;
    end else if (load) begin
      dt_q <= dt_now;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .load_i   (load),
      .cnt_i    (cnt),
      .period_i (period_q),
      .cmp_i    (cmp_i[ch*CNT_W +: CNT_W]),
      .phase_i  (phase_i[ch*CNT_W +: CNT_W]),
      .dt_i     (dt_q),
      .hi_o     (gate_hi[ch]),
      .lo_o     (gate_lo[ch])
    );
  end

  // R7: decoded dead time never exceeds the top of the widest range
  a_r7_span: assert property (@(posedge clk) disable iff (rst)
    dt_q <= dt_cnt_t'(1008));
  // R9: idle forces every gate low at the next edge
  a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gate_hi == '0 && gate_lo == '0));
  // R8: captured dead time holds between wraps
  a_r8_dt_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dt_q));
endmodule

// File: tb/sim_tri_pwm_dt.sv
module sim_tri_pwm_dt;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [W-1:0] period_i = '0;
  logic [3*W-1:0] cmp_i = '0;
  logic [3*W-1:0] phase_i = '0;
  logic [7:0]   dt_code_i = '0;
  logic [2:0]   gate_hi, gate_lo;

  int errors = 0;
  int checks = 0;

  // model settings
  int mP, mDt;
  int mCmp [3];
  int mPh  [3];

  // statistics from the last run
  int hi0_cnt, lo0_cnt, rise0, rise1;

  always #5 clk = ~clk;

  tri_pwm_dt #(.CNT_W(W), .NCH(3)) u0 (
    .clk(clk), .rst(rst), .en(en), .period_i(period_i), .cmp_i(cmp_i),
    .phase_i(phase_i), .dt_code_i(dt_code_i), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R2: reference level from the requirement formula
  function automatic bit ref_at(input int ch, input int i);
    int c, pc;
    if (i < 0) return 1'b0;
    c  = i % (mP + 1);
    pc = (c + mPh[ch]) % (mP + 1);
    return pc < mCmp[ch];
  endfunction

  // R3/R4: gate on side s is high after edge j when the reference sat on s
  // for the dt+1 indices ending at j-1; index -1 is the idle (low) state
  function automatic bit exp_out(input int ch, input bit s, input int j);
    for (int k = 0; k <= mDt; k++) begin
      int idx;
      bit v;
      idx = j - 1 - k;
      if (idx < -1) return 1'b0;
      v = (idx == -1) ? 1'b0 : ref_at(ch, idx);
      if (v != s) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic set_cfg(input int p, input int c0, input int c1, input int c2,
                         input int h0, input int h1, input int h2,
                         input logic [7:0] code, input int dt);
    @(negedge clk);
    en        = 1'b0;
    period_i  = W'(p);
    cmp_i     = {W'(c2), W'(c1), W'(c0)};
    phase_i   = {W'(h2), W'(h1), W'(h0)};
    dt_code_i = code;
    mP = p; mDt = dt;
    mCmp[0] = c0; mCmp[1] = c1; mCmp[2] = c2;
    mPh[0]  = h0; mPh[1]  = h1; mPh[2]  = h2;
    repeat (2) @(negedge clk);
    en = 1'b1;
  endtask

  task automatic compare_run(input int n, input string req);
    int bad = 0;
    int fa = 0, fe = 0;
    bit p0 = 1'b0, p1 = 1'b0;
    hi0_cnt = 0; lo0_cnt = 0; rise0 = -1; rise1 = -1;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      for (int ch = 0; ch < 3; ch++) begin
        bit eh, el;
        eh = exp_out(ch, 1'b1, j);
        el = exp_out(ch, 1'b0, j);
        if (gate_hi[ch] !== eh || gate_lo[ch] !== el) begin
          if (bad == 0) begin
            fa = {gate_hi[ch], gate_lo[ch]};
            fe = {eh, el};
          end
          bad++;
        end
      end
      if (j >= mP + 1 && j <= 2 * mP + 1) begin
        hi0_cnt += int'(gate_hi[0]);
        lo0_cnt += int'(gate_lo[0]);
      end
      if (j >= mP + 1 && gate_hi[0] && !p0 && rise0 < 0) rise0 = j;
      if (j >= mP + 1 && gate_hi[1] && !p1 && rise1 < 0) rise1 = j;
      p0 = gate_hi[0];
      p1 = gate_hi[1];
    end
    check(bad == 0, req, fa, fe);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(gate_hi == 3'b000 && gate_lo == 3'b000, "R9 reset state", {gate_hi, gate_lo}, 0);
    rst = 1'b0;
  endtask

  task automatic t_basic;
    set_cfg(19, 10, 10, 10, 0, 7, 14, 8'd3, 3);
    compare_run(60, "R1 R2 R3 R4 staggered waveform");
    check(hi0_cnt == 7, "R3 main high cycles", hi0_cnt, 7);
    check(lo0_cnt == 7, "R4 complement high cycles", lo0_cnt, 7);
  endtask

  task automatic t_enable;
    int bad = 0;
    @(negedge clk);
    en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (gate_hi != 3'b000 || gate_lo != 3'b000) bad++;
    end
    check(bad == 0, "R9 gates low while idle", bad, 0);
    en = 1'b1;
    compare_run(40, "R9 restart from count 0");
  endtask

  task automatic t_zero_dt;
    int bad = 0;
    set_cfg(9, 4, 4, 4, 0, 3, 9, 8'd0, 0);
    for (int j = 0; j < 30; j++) begin
      @(negedge clk);
      if (j >= 1 && (gate_hi ^ gate_lo) != 3'b111) bad++;
    end
    check(bad == 0, "R5 exact complement at zero dead time", bad, 0);
    set_cfg(9, 4, 4, 4, 0, 3, 9, 8'd0, 0);
    compare_run(40, "R5 zero dead time waveform");
  endtask

  task automatic t_short;
    set_cfg(15, 2, 14, 8, 0, 5, 11, 8'd4, 4);
    compare_run(48, "R6 short pulses");
    check(hi0_cnt == 0, "R6 short main pulse suppressed", hi0_cnt, 0);
    set_cfg(15, 2, 14, 8, 0, 5, 11, 8'd4, 4);
    begin
      int seen = 0;
      for (int j = 0; j < 48; j++) begin
        @(negedge clk);
        if (j >= 8) seen += int'(gate_lo[1]);
      end
      check(seen == 0, "R6 short complement pulse suppressed", seen, 0);
    end
  endtask

  task automatic t_codes;
    set_cfg(299, 150, 150, 150, 0, 100, 299, 8'h7F, 127);
    compare_run(600, "R7 fine range code 0x7F");
    check(hi0_cnt == 23, "R7 fine range width", hi0_cnt, 23);
    set_cfg(599, 300, 300, 300, 0, 100, 599, 8'h94, 168);
    compare_run(1200, "R7 x2 range code 0x94");
    check(hi0_cnt == 132, "R7 x2 range width", hi0_cnt, 132);
    set_cfg(599, 300, 300, 300, 0, 100, 599, 8'hC1, 264);
    compare_run(1200, "R7 x8 range code 0xC1");
    check(lo0_cnt == 36, "R7 x8 range width", lo0_cnt, 36);
    set_cfg(1199, 600, 600, 600, 0, 400, 800, 8'hE0, 512);
    compare_run(2400, "R7 x16 range code 0xE0");
    check(hi0_cnt == 88, "R7 x16 range width", hi0_cnt, 88);
  endtask

  task automatic t_target;
    set_cfg(3359, 1680, 1680, 1680, 0, 504, 1008, 8'h94, 168);
    compare_run(6720, "R10 target waveform");
    check(hi0_cnt == 1512, "R10 target main width", hi0_cnt, 1512);
    check(rise1 - rise0 == 3360 - 504, "R10 phase step between channels", rise1 - rise0, 2856);
  endtask

  task automatic t_reload;
    int bad = 0, cnt = 0, fa = 0, fe = 0;
    set_cfg(19, 10, 10, 10, 0, 0, 0, 8'd2, 2);
    for (int j = 0; j < 80; j++) begin
      @(negedge clk);
      if (j <= 20) begin
        bit eh;
        eh = exp_out(0, 1'b1, j);
        if (gate_hi[0] !== eh) begin
          if (bad == 0) begin fa = int'(gate_hi[0]); fe = int'(eh); end
          bad++;
        end
      end
      if (j == 5) cmp_i[W-1:0] = W'(16);
      if (j >= 60) cnt += int'(gate_hi[0]);
    end
    check(bad == 0, "R8 old compare holds until wrap", fa, fe);
    check(cnt == 14, "R8 new compare after wrap", cnt, 14);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    t_reset();
    t_basic();
    t_enable();
    t_zero_dt();
    t_short();
    t_codes();
    t_target();
    t_reload();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule